// File: doc/BRIEF.md
# Dual-Counter Multi-Mode Timer

This block holds two down-counting timer/counters, A and B, together with a small register-style configuration port. A two-bit mode field decides what each counter does. It can produce a pulse train whose high and low times are programmable. It can latch the running count when an external pin changes, so that the interval between events can be measured. It can run two independent timers, each stepped either by a clock-enable tick or by edges on an event pin. It can also mix an event counter with a periodic timer and one capture channel.

Both event pins pass through a synchronizer before edge detection. Each pin has a selectable active edge. Four sticky flags record counter wraps and captures, and software clears them by writing ones. An interrupt request is raised from the flags whose enable bits are set. The prescaler that makes the tick, the bus wrapper and the pin multiplexing all live outside this block.

Configuration addresses:
- 0: control. Bits [1:0] hold the mode: 0 pulse, 1 dual capture, 2 dual timer, 3 mixed. Bit 2 selects the falling edge for pin 0 and bit 3 does the same for pin 1. Bit 4 steps counter A from pin-0 edges and bit 5 steps counter B from pin-1 edges; both bits act in dual-timer mode only.
- 1: reload A.
- 2: reload B.
- 3: flag clear, write 1 to clear.
- 4: interrupt enable [3:0].

Flag bits: 0 is the A wrap, 1 is the B wrap, 2 is capture 0 and 3 is capture 1.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the pulse output, all four flags, the interrupt request and both capture registers read 0, and the mode is 0 (pulse).
- R2: A counter steps down by one on each step. On a step taken at 0 it loads its reload value instead and sets its wrap flag, so one period spans reload+1 steps.
- R3: In mode 0, counter A steps on tick and the output inverts on every wrap of A. It stays high for reload A + 1 ticks and low for reload B + 1 ticks. In every other mode the output holds its level.
- R4: In mode 1, counter A steps on tick. An active edge on pin 0 copies A into capture 0 and sets flag 2, and an active edge on pin 1 copies A into capture 1 and sets flag 3.
- R5: With its control bit at 0 a pin responds only to rising edges, and with the bit at 1 only to falling edges. The opposite edge changes neither the capture register nor the flag.
- R6: A capture stores the count present just before the third rising clock edge after the pin changes. A capture that coincides with a wrap stores 0 and sets both flags.
- R7: In mode 2 each counter steps on tick when its source bit is 0 and on active edges of its own pin when the bit is 1.
- R8: In mode 3, counter A steps only on active pin-0 edges and ignores tick. Counter B steps on tick, and an active pin-1 edge copies B into capture 1 and sets flag 3.
- R9: Writing 1 to a bit at address 3 clears that flag and writing 0 leaves it. A flag set and a clear in the same cycle leave the flag at 1.
- R10: The interrupt request is high exactly when some flag is 1 and its enable bit is 1.
- R11: A tick-driven counter does not step in cycles where tick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Clock-enable step for tick-driven counters |
| ev_i | input | 2 | Asynchronous event pins 0 and 1 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW (3) | Configuration address |
| cfg_wdata_i | input | CW (16) | Configuration write data |
| pwm_o | output | 1 | Pulse output |
| cap0_o | output | CW (16) | Capture register 0 |
| cap1_o | output | CW (16) | Capture register 1 |
| flags_o | output | 4 | Sticky flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions are timed on purpose. In the first, a pin edge is placed so that its capture lands on the very clock edge where counter A wraps. The bench expects a captured value of 0 with both the wrap flag and the capture flag set. In the second, a flag-clear write is issued in the same cycle as the capture that sets that flag, and the flag must remain set; a later write on its own must clear it. Both cases use the three-edge synchronizer latency to place the pin change relative to a known counter value.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

   typedef enum logic [1:0] {
      MODE_PWM  = 2'd0,
      MODE_CAP2 = 2'd1,
      MODE_TMR2 = 2'd2,
      MODE_MIX  = 2'd3
   } dmt_mode_e;

   typedef struct packed {
      logic      src_b_ev;
      logic      src_a_ev;
      logic      ev1_fall;
      logic      ev0_fall;
      dmt_mode_e mode;
   } dmt_ctrl_t;

   localparam int unsigned FLAG_N   = 4;
   localparam int unsigned ADR_CTRL = 0;
   localparam int unsigned ADR_RLDA = 1;
   localparam int unsigned ADR_RLDB = 2;
   localparam int unsigned ADR_CLR  = 3;
   localparam int unsigned ADR_IEN  = 4;

endpackage

// File: rtl/dmt_edge_sync.sv
module dmt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic fall_sel_i,
   output logic hit_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dmt_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;
   logic              synced;

   assign synced = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= synced;
      end
   end

   assign hit_o = fall_sel_i ? (last_q & ~synced) : (~last_q & synced);

endmodule

// File: rtl/dmt_down_counter.sv
module dmt_down_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic [W-1:0] reload_i,
   output logic [W-1:0] value_o,
   output logic         wrap_o
);

   assign wrap_o = step_i && (value_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_o <= '0;
      end else if (step_i) begin
         value_o <= wrap_o ? reload_i : value_o - W'(1);
      end
   end

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
   import dmt_pkg::*;
#(
   parameter int CW          = 16,
   parameter int AW          = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [1:0]        ev_i,
   input  logic              cfg_we_i,
   input  logic [AW-1:0]     cfg_addr_i,
   input  logic [CW-1:0]     cfg_wdata_i,
   output logic              pwm_o,
   output logic [CW-1:0]     cap0_o,
   output logic [CW-1:0]     cap1_o,
   output logic [FLAG_N-1:0] flags_o,
   output logic              irq_o
);

   localparam int NCH    = 2;
   localparam int CTRL_W = $bits(dmt_ctrl_t);
   localparam logic [AW-1:0] A_CTRL = AW'(ADR_CTRL);
   localparam logic [AW-1:0] A_RLDA = AW'(ADR_RLDA);
   localparam logic [AW-1:0] A_RLDB = AW'(ADR_RLDB);
   localparam logic [AW-1:0] A_CLR  = AW'(ADR_CLR);
   localparam logic [AW-1:0] A_IEN  = AW'(ADR_IEN);

   generate
      if (CW < CTRL_W) begin : g_bad_cw
         $error("dual_mode_timer: CW too narrow for control word");
      end
      if (AW < 3) begin : g_bad_aw
         $error("dual_mode_timer: AW must be at least 3");
      end
   endgenerate

   // configuration state
   dmt_ctrl_t         ctrl_q;
   logic [CW-1:0]     rld_q [NCH];
   logic [FLAG_N-1:0] ien_q;
   dmt_mode_e         mode_q;

   assign mode_q = ctrl_q.mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         rld_q[0] <= '0;
         rld_q[1] <= '0;
         ien_q    <= '0;
      end else if (cfg_we_i) begin
         if (cfg_addr_i == A_CTRL) ctrl_q   <= dmt_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
         if (cfg_addr_i == A_RLDA) rld_q[0] <= cfg_wdata_i;
         if (cfg_addr_i == A_RLDB) rld_q[1] <= cfg_wdata_i;
         if (cfg_addr_i == A_IEN)  ien_q    <= cfg_wdata_i[FLAG_N-1:0];
      end
   end

   // per-channel synchronizer and counter
   logic [NCH-1:0] hit;
   logic [NCH-1:0] step;
   logic [NCH-1:0] wrap;
   logic [NCH-1:0] fall_vec;
   logic [CW-1:0]  cnt    [NCH];
   logic [CW-1:0]  reload [NCH];
   logic           pwm_q;
   logic           wrap_a;

   assign fall_vec = {ctrl_q.ev1_fall, ctrl_q.ev0_fall};
   assign wrap_a   = wrap[0];

   // counter A alternates its reload between high and low time in pulse mode
   assign reload[0] = (mode_q == MODE_PWM && pwm_q) ? rld_q[1] : rld_q[0];
   assign reload[1] = rld_q[1];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         dmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (ev_i[c]),
            .fall_sel_i (fall_vec[c]),
            .hit_o      (hit[c])
         );
         dmt_down_counter #(.W(CW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (step[c]),
            .reload_i (reload[c]),
            .value_o  (cnt[c]),
            .wrap_o   (wrap[c])
         );
      end
   endgenerate

   // mode personality: who steps, who captures
   logic [NCH-1:0] cap_evt;
   logic           cap1_from_b;

   always_comb begin
      step        = '0;
      cap_evt     = '0;
      cap1_from_b = 1'b0;
      case (mode_q)
         MODE_PWM: begin
            step[0] = tick_i;
         end
         MODE_CAP2: begin
            step[0] = tick_i;
            cap_evt = hit;
         end
         MODE_TMR2: begin
            step[0] = ctrl_q.src_a_ev ? hit[0] : tick_i;
            step[1] = ctrl_q.src_b_ev ? hit[1] : tick_i;
         end
         MODE_MIX: begin
            step[0]     = hit[0];
            step[1]     = tick_i;
            cap_evt[1]  = hit[1];
            cap1_from_b = 1'b1;
         end
         default: ;
      endcase
   end

   // output pulse, capture holding registers, flags
   logic [FLAG_N-1:0] flag_set;
   logic [FLAG_N-1:0] flag_clr;

   assign flag_set = {cap_evt[1], cap_evt[0], wrap[1], wrap[0]};
   assign flag_clr = (cfg_we_i && cfg_addr_i == A_CLR) ? cfg_wdata_i[FLAG_N-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q   <= 1'b0;
         cap0_o  <= '0;
         cap1_o  <= '0;
         flags_o <= '0;
      end else begin
         if (mode_q == MODE_PWM && wrap[0]) pwm_q <= ~pwm_q;
         if (cap_evt[0]) cap0_o <= cnt[0];
         if (cap_evt[1]) cap1_o <= cap1_from_b ? cnt[1] : cnt[0];
         flags_o <= (flags_o & ~flag_clr) | flag_set;
      end
   end

   assign pwm_o = pwm_q;
   assign irq_o = |(flags_o & ien_q);

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
   import dmt_pkg::*;
#(
   parameter int CW = 16,
   parameter int AW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we_i,
   input logic [AW-1:0]     cfg_addr_i,
   input logic [FLAG_N-1:0] clr_data_i,
   input logic              pwm_o,
   input logic [CW-1:0]     cap0_o,
   input logic [FLAG_N-1:0] flags_o,
   input logic              irq_o,
   input dmt_mode_e         mode_i,
   input logic              wrap_a_i,
   input logic              cap0_evt_i
);

   logic [FLAG_N-1:0] clr_v;
   assign clr_v = (cfg_we_i && cfg_addr_i == AW'(ADR_CLR)) ? clr_data_i : '0;

   // R3: outside pulse mode the output keeps its level
   p_pwm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != MODE_PWM) |=> $stable(pwm_o));

   // R3: a wrap of A in pulse mode inverts the output
   p_pwm_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_PWM && wrap_a_i) |=> (pwm_o != $past(pwm_o)));

   // R2: a wrap of A is recorded in flag 0
   p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_a_i |=> flags_o[0]);

   // R4: capture 0 only moves on a capture event
   p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cap0_evt_i |=> $stable(cap0_o));

   // R9: a set flag only falls when a clear names it
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flags_o) & ~$past(clr_v)) & ~flags_o) == '0));

   // R10: no request without a flag
   p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags_o != '0));

endmodule

bind dual_mode_timer dmt_checker #(.CW(CW), .AW(AW)) u_dmt_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we_i   (cfg_we_i),
   .cfg_addr_i (cfg_addr_i),
   .clr_data_i (cfg_wdata_i[3:0]),
   .pwm_o      (pwm_o),
   .cap0_o     (cap0_o),
   .flags_o    (flags_o),
   .irq_o      (irq_o),
   .mode_i     (mode_q),
   .wrap_a_i   (wrap_a),
   .cap0_evt_i (cap_evt[0])
);

// File: tb/dual_mode_timer_bench.sv
`timescale 1ns/1ps
module dual_mode_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        tick_half = 1'b0;
   logic [1:0]  ev = 2'b00;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        pwm;
   logic [15:0] cap0, cap1;
   logic [3:0]  flags;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dual_mode_timer u_dual_mode_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .ev_i(ev),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .pwm_o(pwm), .cap0_o(cap0), .cap1_o(cap1),
      .flags_o(flags), .irq_o(irq)
   );

   initial forever begin
      @(negedge clk);
      tick <= tick_half ? ~tick : 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic pulse0();
      ev[0] = 1'b1; repeat (4) @(negedge clk);
      ev[0] = 1'b0; repeat (4) @(negedge clk);
   endtask

   task automatic poll_flag(input int b);
      for (int i = 0; i < 400 && !flags[b]; i++) @(negedge clk);
   endtask

   task automatic measure_pwm(output int hi, output int lo);
      logic prev;
      prev = pwm;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (pwm && !prev) break;
         prev = pwm;
      end
      hi = 0; lo = 0;
      while (pwm && hi < 400) begin hi++; @(negedge clk); end
      while (!pwm && lo < 400) begin lo++; @(negedge clk); end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int hi, lo, n, d;
      logic [15:0] c_old;
      logic held;
      logic p0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(pwm == 0,   "R1 pwm",   pwm, 0);
      chk(flags == 0, "R1 flags", flags, 0);
      chk(irq == 0,   "R1 irq",   irq, 0);
      chk(cap0 == 0 && cap1 == 0, "R1 captures", cap0 + cap1, 0);

      // R3 pulse sweep (mode 0 is the reset mode)
      for (int ra = 0; ra < 4; ra++) begin
         for (int rb = 0; rb < 4; rb++) begin
            wr(3'd1, 16'(ra));
            wr(3'd2, 16'(rb));
            measure_pwm(hi, lo);
            chk(hi == ra + 1, "R3 high time", hi, ra + 1);
            chk(lo == rb + 1, "R3 low time",  lo, rb + 1);
         end
      end
      // R11 half-rate tick stretches both phases
      tick_half = 1'b1;
      wr(3'd1, 16'd2); wr(3'd2, 16'd1);
      measure_pwm(hi, lo);
      measure_pwm(hi, lo);
      chk(hi == 6, "R11 high time half tick", hi, 6);
      chk(lo == 4, "R11 low time half tick",  lo, 4);
      tick_half = 1'b0;
      // R3 output holds outside pulse mode
      wr(3'd0, 16'h0001);
      p0 = pwm; held = 1'b1;
      repeat (30) begin @(negedge clk); if (pwm != p0) held = 1'b0; end
      chk(held, "R3 hold in mode 1", pwm, p0);

      // R4 dual capture interval sweep
      wr(3'd1, 16'd100);
      repeat (110) @(negedge clk);
      for (int k = 1; k <= 20; k++) begin
         wr(3'd3, 16'hF);
         ev[0] = 1'b1;
         repeat (k) @(negedge clk);
         ev[1] = 1'b1;
         repeat (5) @(negedge clk);
         d = (int'(cap0) - int'(cap1) + 101) % 101;
         chk(d == k, "R4 capture interval", d, k);
         if (k == 1) chk(flags[3:2] == 2'b11, "R4 capture flags", flags[3:2], 3);
         ev = 2'b00;
         repeat (5) @(negedge clk);
      end

      // R5 falling-edge select on pin 0
      wr(3'd0, 16'h0005);
      wr(3'd3, 16'hF);
      c_old = cap0;
      ev[0] = 1'b1; repeat (6) @(negedge clk);
      chk(flags[2] == 0, "R5 rising ignored flag", flags[2], 0);
      chk(cap0 == c_old, "R5 rising ignored cap", cap0, c_old);
      ev[0] = 1'b0; repeat (6) @(negedge clk);
      chk(flags[2] == 1, "R5 falling captured", flags[2], 1);

      // R6 synchronizer latency
      wr(3'd0, 16'h0001);
      wr(3'd1, 16'd50);
      repeat (110) @(negedge clk);
      wr(3'd3, 16'hF);
      poll_flag(0);
      ev[0] = 1'b1; repeat (5) @(negedge clk);
      chk(cap0 == 48, "R6 capture latency", cap0, 48);
      ev[0] = 1'b0; repeat (5) @(negedge clk);
      // R6 capture coinciding with wrap
      wr(3'd1, 16'd10);
      wr(3'd3, 16'hF);
      poll_flag(0);
      wr(3'd3, 16'hF);
      repeat (7) @(negedge clk);
      ev[0] = 1'b1; repeat (5) @(negedge clk);
      chk(cap0 == 0, "R6 capture at wrap value", cap0, 0);
      chk(flags[0] && flags[2], "R6 capture at wrap flags", flags, 5);
      ev[0] = 1'b0; repeat (5) @(negedge clk);

      // R9 set wins over clear, then W1C
      wr(3'd3, 16'hF);
      ev[0] = 1'b1;
      repeat (2) @(negedge clk);
      wr(3'd3, 16'h4);
      chk(flags[2] == 1, "R9 set wins", flags[2], 1);
      wr(3'd3, 16'h8);
      chk(flags[2] == 1, "R9 zero bit keeps flag", flags[2], 1);
      wr(3'd3, 16'h4);
      chk(flags[2] == 0, "R9 write one clears", flags[2], 0);
      ev[0] = 1'b0; repeat (5) @(negedge clk);

      // R10 interrupt with frozen flags (mode 2, both counters event-driven)
      wr(3'd0, 16'h0032);
      repeat (3) @(negedge clk);
      for (int e = 0; e < 16; e++) begin
         wr(3'd4, 16'(e));
         chk(irq == |(flags & 4'(e)), "R10 irq", irq, |(flags & 4'(e)));
      end
      wr(3'd4, 16'h0);

      // R7 mode 2: A on pin-0 edges, B on tick
      wr(3'd0, 16'h0012);
      wr(3'd1, 16'd3);
      wr(3'd2, 16'd5);
      wr(3'd3, 16'hF);
      for (int i = 0; i < 10 && !flags[0]; i++) pulse0();
      wr(3'd3, 16'hF);
      repeat (3) pulse0();
      chk(flags[0] == 0, "R7 event count before wrap", flags[0], 0);
      pulse0();
      chk(flags[0] == 1, "R7 event count wrap", flags[0], 1);
      wr(3'd3, 16'hF);
      poll_flag(1);
      wr(3'd3, 16'h2);
      n = 1;
      while (!flags[1] && n < 100) begin @(negedge clk); n++; end
      chk(n == 6, "R7 tick timer period", n, 6);
      // R11 gated tick doubles the period
      tick_half = 1'b1;
      wr(3'd3, 16'hF);
      poll_flag(1);
      wr(3'd3, 16'h2);
      n = 1;
      while (!flags[1] && n < 100) begin @(negedge clk); n++; end
      chk(n == 12, "R11 gated timer period", n, 12);
      tick_half = 1'b0;

      // R8 mixed mode
      wr(3'd0, 16'h0003);
      wr(3'd3, 16'hF);
      repeat (40) @(negedge clk);
      chk(flags[0] == 0, "R8 A ignores tick", flags[0], 0);
      for (int i = 0; i < 10 && !flags[0]; i++) pulse0();
      wr(3'd3, 16'hF);
      repeat (3) pulse0();
      chk(flags[0] == 0, "R8 A event count before wrap", flags[0], 0);
      pulse0();
      chk(flags[0] == 1, "R8 A event count wrap", flags[0], 1);
      wr(3'd3, 16'hF);
      poll_flag(1);
      ev[1] = 1'b1; repeat (5) @(negedge clk);
      chk(cap1 == 3, "R8 capture of B", cap1, 3);
      chk(flags[3] == 1, "R8 capture flag", flags[3], 1);
      ev[1] = 1'b0; repeat (5) @(negedge clk);

      finish_run();
   end

endmodule